// File: doc/BRIEF.md
# Four-Lane Interleaved Vector Arithmetic Unit

This block holds a bank of vector registers and applies one integer element-wise operation at a time across them. The storage and the arithmetic are cut into four lanes. Element `i` of every register sits in lane `i mod 4` only. A command therefore moves one group of four elements per clock through four identical lane pipelines, and no lane needs data from another lane. A scalar operand is sampled once, when the command is accepted, and is then fed to all four lanes for the whole command.

A command names a destination register, two source registers or one source register plus a scalar, an operation (add, subtract, low-half multiply), an operand form and a length. While the command runs, `busy` blocks further commands and host accesses. A single-cycle `done` follows the last write-back. A simple host port loads and reads individual elements so that register contents can be set up and inspected.

Top module: `vlane_datapath`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and `host_rd_valid` are all low.
- R2: With `busy` low, a host write stores `host_wr_data` into element `host_wr_idx` of register `host_wr_reg`. A host read request returns that element on `host_rd_data`, with `host_rd_valid` high, exactly two cycles after the request cycle.
- R3: The vector-vector form (`cmd_form` = 0) computes, for each element e, `vs1[e] op vs2[e]` into `vd[e]`. The value of `cmd_op` selects the operation: 0 add, 1 subtract, 2 multiply keeping the low 64 bits, and 3 also adds. All arithmetic wraps modulo 2^64.
- R4: The vector-scalar form (`cmd_form` = 1) computes `vs1[e] op scalar`. The scalar is the value of `cmd_scalar` in the accept cycle, and later changes of `cmd_scalar` have no effect on the result.
- R5: The reversed form (`cmd_form` = 2) computes `scalar op vs1[e]`, so subtract yields the scalar minus each element. A form value of 3 behaves as vector-vector.
- R6: Only elements 0 to len-1 of the destination are written. Elements at or above the length keep their previous value, including the unused lanes of a partially filled last group.
- R7: A command with length 0 writes nothing, never raises `busy`, and raises `done` in the cycle after the accept cycle.
- R8: A command with length L > 0 raises `busy` from the cycle after acceptance. `done` is high for one cycle, ceil(L/4)+4 cycles after the accept cycle, and in that cycle `busy` is already low.
- R9: While `busy` is high, `cmd_valid`, host writes and host reads are ignored.
- R10: A length above 64 is treated as 64.
- R11: The destination may equal a source register. Each element is then computed from that element's value before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, accepted when `busy` is low |
| cmd_op | input | 2 | 0 add, 1 subtract, 2 multiply low half, 3 add |
| cmd_form | input | 2 | 0 vector-vector, 1 vector-scalar, 2 scalar-vector, 3 vector-vector |
| cmd_vd | input | 3 | Destination register |
| cmd_vs1 | input | 3 | First source register |
| cmd_vs2 | input | 3 | Second source register (vector-vector only) |
| cmd_scalar | input | 64 | Scalar operand, sampled at accept |
| cmd_len | input | 7 | Element count, 0 to 64, larger values clamp to 64 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| host_wr_en | input | 1 | Host element write |
| host_wr_reg | input | 3 | Host write register |
| host_wr_idx | input | 6 | Host write element index |
| host_wr_data | input | 64 | Host write data |
| host_rd_en | input | 1 | Host element read request |
| host_rd_reg | input | 3 | Host read register |
| host_rd_idx | input | 6 | Host read element index |
| host_rd_valid | output | 1 | Read data valid, two cycles after request |
| host_rd_data | output | 64 | Read data |

## Verification
Several properties hold on every cycle and are checked there. `busy` and `done` are never high together. A length-zero accept yields `done` with `busy` still low. A non-zero accept raises `busy`. Every fall of `busy` coincides with `done`. Host read data arrives with a fixed two-cycle latency. Some behaviour can only be shown by the bench's scenarios against a reference model of the register contents: the element values for each operation and form, the interleaved placement across lanes, the untouched tail beyond the length, the scalar snapshot, in-place operation, the length clamp, the exact completion cycle and the requests dropped while busy.

// File: rtl/vlane_pkg.sv
package vlane_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_MUL  = 2'd2,
    OP_ADD2 = 2'd3
  } vop_e;

  typedef enum logic [1:0] {
    FM_VV  = 2'd0,
    FM_VS  = 2'd1,
    FM_SV  = 2'd2,
    FM_VV2 = 2'd3
  } vform_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RUN   = 2'd1,
    SQ_DRAIN = 2'd2
  } vseq_state_e;

  // read stage plus two arithmetic stages between issue and write-back
  localparam int unsigned PIPE_DEPTH = 3;

endpackage

// File: rtl/vlane_bank.sv
module vlane_bank #(
  parameter int unsigned EW    = 64,
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [EW-1:0] rdata_a,
  output logic [EW-1:0] rdata_b
);

  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end

endmodule

// File: rtl/vlane_alu.sv
module vlane_alu
  import vlane_pkg::*;
#(
  parameter int unsigned EW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  vop_e          op,
  input  vform_e        form,
  input  logic [EW-1:0] opa,
  input  logic [EW-1:0] opb,
  input  logic [EW-1:0] scalar,
  output logic          out_vld,
  output logic [EW-1:0] out_res
);

  logic [EW-1:0] x, y, r;
  logic [EW-1:0] res1;
  logic          vld1;

  always_comb begin
    x = (form == FM_SV) ? scalar : opa;
    case (form)
      FM_VS:   y = scalar;
      FM_SV:   y = opa;
      default: y = opb;
    endcase
    case (op)
      OP_SUB:  r = x - y;
      OP_MUL:  r = x * y;
      default: r = x + y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld1    <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      vld1    <= in_vld;
      out_vld <= vld1;
    end
  end

  always_ff @(posedge clk) begin
    res1    <= r;
    out_res <= res1;
  end

endmodule

// File: rtl/vlane_seq.sv
module vlane_seq
  import vlane_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned VLMAX = 64,
  parameter int unsigned NREG  = 8,
  parameter int unsigned EW    = 64,
  localparam int unsigned LW   = $clog2(VLMAX + 1),
  localparam int unsigned GW   = $clog2(NREG),
  localparam int unsigned RW   = $clog2(VLMAX / LANES),
  localparam int unsigned LSW  = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [1:0]       cmd_form,
  input  logic [GW-1:0]    cmd_vd,
  input  logic [GW-1:0]    cmd_vs1,
  input  logic [GW-1:0]    cmd_vs2,
  input  logic [EW-1:0]    cmd_scalar,
  input  logic [LW-1:0]    cmd_len,
  output logic             busy,
  output logic             done,
  output vop_e             op_q,
  output vform_e           form_q,
  output logic [GW-1:0]    vd_q,
  output logic [GW-1:0]    vs1_q,
  output logic [GW-1:0]    vs2_q,
  output logic [EW-1:0]    scalar_q,
  output logic             iss_vld,
  output logic [RW-1:0]    iss_row,
  output logic [LANES-1:0] iss_mask
);

  localparam logic [LW-1:0] LEN_MAX   = LW'(VLMAX);
  localparam logic [LW-1:0] LANE_RND  = LW'(LANES - 1);
  localparam logic [1:0]    DRAIN_TOP = 2'(PIPE_DEPTH - 1);

  vseq_state_e   state;
  logic [RW-1:0] grp_q;
  logic [RW-1:0] last_grp_q;
  logic [1:0]    drain_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] len_eff;
  logic [LW-1:0] n_grp;
  logic          accept;

  assign accept  = cmd_valid && (state == SQ_IDLE);
  assign len_eff = (cmd_len > LEN_MAX) ? LEN_MAX : cmd_len;
  assign n_grp   = (len_eff + LANE_RND) >> LSW;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      busy       <= 1'b0;
      done       <= 1'b0;
      grp_q      <= '0;
      last_grp_q <= '0;
      drain_q    <= '0;
      len_q      <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (accept) begin
            len_q <= len_eff;
            if (len_eff == '0) begin
              done <= 1'b1;
            end else begin
              state      <= SQ_RUN;
              busy       <= 1'b1;
              grp_q      <= '0;
              last_grp_q <= RW'(n_grp - 1'b1);
            end
          end
        end
        SQ_RUN: begin
          grp_q <= grp_q + 1'b1;
          if (grp_q == last_grp_q) begin
            state   <= SQ_DRAIN;
            drain_q <= DRAIN_TOP;
          end
        end
        SQ_DRAIN: begin
          if (drain_q == '0) begin
            state <= SQ_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            drain_q <= drain_q - 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      op_q     <= vop_e'(cmd_op);
      form_q   <= vform_e'(cmd_form);
      vd_q     <= cmd_vd;
      vs1_q    <= cmd_vs1;
      vs2_q    <= cmd_vs2;
      scalar_q <= cmd_scalar;
    end
  end

  assign iss_vld = (state == SQ_RUN);
  assign iss_row = grp_q;

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      iss_mask[k] = iss_vld && (LW'({grp_q, LSW'(k)}) < len_q);
    end
  end

endmodule

// File: rtl/vlane_datapath.sv
module vlane_datapath
  import vlane_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned NREG  = 8,
  parameter int unsigned VLMAX = 64,
  parameter int unsigned EW    = 64,
  localparam int unsigned LW   = $clog2(VLMAX + 1),
  localparam int unsigned GW   = $clog2(NREG),
  localparam int unsigned IW   = $clog2(VLMAX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [1:0]    cmd_form,
  input  logic [GW-1:0] cmd_vd,
  input  logic [GW-1:0] cmd_vs1,
  input  logic [GW-1:0] cmd_vs2,
  input  logic [EW-1:0] cmd_scalar,
  input  logic [LW-1:0] cmd_len,
  output logic          busy,
  output logic          done,
  input  logic          host_wr_en,
  input  logic [GW-1:0] host_wr_reg,
  input  logic [IW-1:0] host_wr_idx,
  input  logic [EW-1:0] host_wr_data,
  input  logic          host_rd_en,
  input  logic [GW-1:0] host_rd_reg,
  input  logic [IW-1:0] host_rd_idx,
  output logic          host_rd_valid,
  output logic [EW-1:0] host_rd_data
);

  localparam int unsigned LSW   = $clog2(LANES);
  localparam int unsigned RW    = $clog2(VLMAX / LANES);
  localparam int unsigned DEPTH = NREG * (VLMAX / LANES);
  localparam int unsigned AW    = GW + RW;

  vop_e             op_q;
  vform_e           form_q;
  logic [GW-1:0]    vd_q, vs1_q, vs2_q;
  logic [EW-1:0]    scalar_q;
  logic             iss_vld;
  logic [RW-1:0]    iss_row;
  logic [LANES-1:0] iss_mask;

  vlane_seq #(
    .LANES(LANES), .VLMAX(VLMAX), .NREG(NREG), .EW(EW)
  ) seq_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_form   (cmd_form),
    .cmd_vd     (cmd_vd),
    .cmd_vs1    (cmd_vs1),
    .cmd_vs2    (cmd_vs2),
    .cmd_scalar (cmd_scalar),
    .cmd_len    (cmd_len),
    .busy       (busy),
    .done       (done),
    .op_q       (op_q),
    .form_q     (form_q),
    .vd_q       (vd_q),
    .vs1_q      (vs1_q),
    .vs2_q      (vs2_q),
    .scalar_q   (scalar_q),
    .iss_vld    (iss_vld),
    .iss_row    (iss_row),
    .iss_mask   (iss_mask)
  );

  // Row tag travels alongside the read and arithmetic stages
  logic [LANES-1:0] mask_d1;
  logic [RW-1:0]    row_d1, row_d2, row_d3;

  always_ff @(posedge clk) begin
    if (rst) mask_d1 <= '0;
    else     mask_d1 <= iss_mask;
  end

  always_ff @(posedge clk) begin
    row_d1 <= iss_row;
    row_d2 <= row_d1;
    row_d3 <= row_d2;
  end

  logic [AW-1:0] rd_addr_a, rd_addr_b;
  assign rd_addr_a = busy ? {vs1_q, iss_row} : {host_rd_reg, host_rd_idx[IW-1:LSW]};
  assign rd_addr_b = {vs2_q, iss_row};

  logic [EW-1:0] lane_rd_a [LANES];
  logic          host_wr_ok;
  assign host_wr_ok = host_wr_en && !busy;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [EW-1:0] rd_b;
    logic          wb_vld;
    logic [EW-1:0] wb_res;
    logic          we;
    logic [AW-1:0] waddr;
    logic [EW-1:0] wdata;

    always_comb begin
      if (wb_vld) begin
        we    = 1'b1;
        waddr = {vd_q, row_d3};
        wdata = wb_res;
      end else begin
        we    = host_wr_ok && (host_wr_idx[LSW-1:0] == LSW'(k));
        waddr = {host_wr_reg, host_wr_idx[IW-1:LSW]};
        wdata = host_wr_data;
      end
    end

    vlane_bank #(.EW(EW), .DEPTH(DEPTH)) bank_i (
      .clk     (clk),
      .we      (we),
      .waddr   (waddr),
      .wdata   (wdata),
      .raddr_a (rd_addr_a),
      .raddr_b (rd_addr_b),
      .rdata_a (lane_rd_a[k]),
      .rdata_b (rd_b)
    );

    vlane_alu #(.EW(EW)) alu_i (
      .clk     (clk),
      .rst     (rst),
      .in_vld  (mask_d1[k]),
      .op      (op_q),
      .form    (form_q),
      .opa     (lane_rd_a[k]),
      .opb     (rd_b),
      .scalar  (scalar_q),
      .out_vld (wb_vld),
      .out_res (wb_res)
    );
  end

  // Host read: bank read stage, then lane select into output register
  logic           rd_p1;
  logic [LSW-1:0] rd_sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_p1         <= 1'b0;
      host_rd_valid <= 1'b0;
    end else begin
      rd_p1         <= host_rd_en && !busy;
      host_rd_valid <= rd_p1;
    end
  end

  always_ff @(posedge clk) begin
    rd_sel_q <= host_rd_idx[LSW-1:0];
    if (rd_p1) host_rd_data <= lane_rd_a[rd_sel_q];
  end

endmodule

// File: rtl/vlane_datapath_chk.sv
module vlane_datapath_chk #(
  parameter int unsigned LW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [LW-1:0] cmd_len,
  input logic          busy,
  input logic          done,
  input logic          host_rd_en,
  input logic          host_rd_valid
);

  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_len == '0) |=> (done && !busy));

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_len != '0) |=> (busy && !done));

  // R8
  drain_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd_en && !busy) |=> ##1 host_rd_valid);

  // R9
  rd_source_chk: assert property (@(posedge clk) disable iff (rst)
    host_rd_valid |-> $past(host_rd_en && !busy, 2));

endmodule

bind vlane_datapath vlane_datapath_chk #(.LW(LW)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .cmd_valid     (cmd_valid),
  .cmd_len       (cmd_len),
  .busy          (busy),
  .done          (done),
  .host_rd_en    (host_rd_en),
  .host_rd_valid (host_rd_valid)
);

// File: tb/vlane_datapath_tb_top.sv
`timescale 1ns/1ps
module vlane_datapath_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [1:0]  cmd_form = '0;
  logic [2:0]  cmd_vd = '0, cmd_vs1 = '0, cmd_vs2 = '0;
  logic [63:0] cmd_scalar = '0;
  logic [6:0]  cmd_len = '0;
  logic        busy, done;
  logic        host_wr_en = 1'b0;
  logic [2:0]  host_wr_reg = '0;
  logic [5:0]  host_wr_idx = '0;
  logic [63:0] host_wr_data = '0;
  logic        host_rd_en = 1'b0;
  logic [2:0]  host_rd_reg = '0;
  logic [5:0]  host_rd_idx = '0;
  logic        host_rd_valid;
  logic [63:0] host_rd_data;

  always #2.5 clk = ~clk;

  vlane_datapath dut_i (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_form(cmd_form),
    .cmd_vd(cmd_vd), .cmd_vs1(cmd_vs1), .cmd_vs2(cmd_vs2),
    .cmd_scalar(cmd_scalar), .cmd_len(cmd_len),
    .busy(busy), .done(done),
    .host_wr_en(host_wr_en), .host_wr_reg(host_wr_reg),
    .host_wr_idx(host_wr_idx), .host_wr_data(host_wr_data),
    .host_rd_en(host_rd_en), .host_rd_reg(host_rd_reg),
    .host_rd_idx(host_rd_idx), .host_rd_valid(host_rd_valid),
    .host_rd_data(host_rd_data)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [63:0] mdl [8][64];
  logic [63:0] q_exp [$];
  string       q_tag [$];

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_op(input int op, input int form,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] s);
    logic [63:0] x, y;
    x = (form == 2) ? s : a;
    y = (form == 1) ? s : ((form == 2) ? a : b);
    case (op)
      1: return x - y;
      2: return x * y;
      default: return x + y;
    endcase
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && host_rd_valid) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R2 unexpected read data", host_rd_data, 64'h0);
      end else begin
        logic [63:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check(host_rd_data === e, t, host_rd_data, e);
      end
    end
  end

  task automatic host_write(input int r, input int i, input logic [63:0] d);
    host_wr_en = 1'b1; host_wr_reg = r[2:0]; host_wr_idx = i[5:0]; host_wr_data = d;
    tick();
    host_wr_en = 1'b0;
    mdl[r][i] = d;
  endtask

  task automatic read_reg(input int r, input string tag);
    for (int i = 0; i < 64; i++) begin
      host_rd_en = 1'b1; host_rd_reg = r[2:0]; host_rd_idx = i[5:0];
      q_exp.push_back(mdl[r][i]);
      q_tag.push_back($sformatf("%s reg%0d elem%0d", tag, r, i));
      tick();
    end
    host_rd_en = 1'b0;
    repeat (3) tick();
  endtask

  task automatic run_cmd(input int op, input int form, input int vd, input int vs1,
      input int vs2, input logic [63:0] s, input int len, input string tag);
    int leff, g, expc, cnt;
    cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_form = form[1:0];
    cmd_vd = vd[2:0]; cmd_vs1 = vs1[2:0]; cmd_vs2 = vs2[2:0];
    cmd_scalar = s; cmd_len = len[6:0];
    tick();
    cmd_valid = 1'b0;
    cmd_scalar = ~s;  // R4: later scalar changes must not matter
    leff = (len > 64) ? 64 : len;
    g = (leff + 3) / 4;
    expc = (leff == 0) ? 1 : g + 4;
    if (leff > 0) check(busy === 1'b1, {tag, " R8 busy after accept"}, 64'(busy), 64'h1);
    else          check(busy === 1'b0, {tag, " R7 busy stays low"}, 64'(busy), 64'h0);
    cnt = 1;
    while (done !== 1'b1 && cnt < 400) begin
      tick();
      cnt++;
    end
    check(cnt == expc, {tag, (leff == 0) ? " R7 done cycle" : " R8 done cycle"},
          64'(cnt), 64'(expc));
    check(busy === 1'b0, {tag, " R8 busy low at done"}, 64'(busy), 64'h0);
    for (int e = 0; e < leff; e++)
      mdl[vd][e] = ref_op(op, form, mdl[vs1][e], mdl[vs2][e], s);
    tick();
    check(done === 1'b0, {tag, " R8 done one cycle"}, 64'(done), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check(busy === 1'b0, "R1 busy after reset", 64'(busy), 64'h0);
    check(done === 1'b0, "R1 done after reset", 64'(done), 64'h0);
    check(host_rd_valid === 1'b0, "R1 rd_valid after reset", 64'(host_rd_valid), 64'h0);

    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 64; i++)
        host_write(r, i, 64'h9E37_79B9_7F4A_7C15 * 64'(r * 64 + i + 1) ^ 64'(i << 40));

    read_reg(0, "R2");
    read_reg(5, "R2");

    run_cmd(0, 0, 2, 0, 1, 64'h0, 64, "R3 vv add");
    read_reg(2, "R3");
    run_cmd(1, 0, 3, 0, 1, 64'h0, 64, "R3 vv sub");
    read_reg(3, "R3");
    run_cmd(2, 0, 4, 0, 1, 64'h0, 64, "R3 vv mul");
    read_reg(4, "R3");
    run_cmd(3, 3, 7, 4, 2, 64'h0, 64, "R5 op3 form3");
    read_reg(7, "R5");

    run_cmd(0, 1, 5, 0, 6, 64'h0123_4567_89AB_CDEF, 64, "R4 vs add");
    read_reg(5, "R4");
    run_cmd(2, 1, 6, 1, 6, 64'hFFFF_FFFF_0000_0003, 64, "R4 vs mul");
    read_reg(6, "R4");
    run_cmd(1, 2, 6, 1, 0, 64'h0000_0000_0000_0010, 64, "R5 rev sub");
    read_reg(6, "R5");

    run_cmd(1, 0, 2, 3, 4, 64'h0, 10, "R6 len10");
    read_reg(2, "R6");
    run_cmd(0, 0, 3, 3, 3, 64'h0, 1, "R6 len1");
    read_reg(3, "R6");
    run_cmd(0, 0, 3, 0, 1, 64'h0, 0, "R7 len0");
    read_reg(3, "R7");
    run_cmd(2, 0, 4, 5, 6, 64'h0, 100, "R10 len100");
    read_reg(4, "R10");
    run_cmd(1, 1, 1, 1, 0, 64'h0000_0000_DEAD_BEEF, 64, "R11 in place");
    read_reg(1, "R11");

    // R9: requests while busy are dropped
    begin
      int cnt;
      cmd_valid = 1'b1; cmd_op = 2'd0; cmd_form = 2'd0;
      cmd_vd = 3'd2; cmd_vs1 = 3'd0; cmd_vs2 = 3'd1; cmd_len = 7'd64;
      tick();
      cmd_op = 2'd2; cmd_vd = 3'd7; cmd_vs1 = 3'd5; cmd_vs2 = 3'd5;
      host_wr_en = 1'b1; host_wr_reg = 3'd7; host_wr_idx = 6'd5;
      host_wr_data = 64'hDEAD_0000_BEEF_0000;
      host_rd_en = 1'b1; host_rd_reg = 3'd7; host_rd_idx = 6'd1;
      repeat (3) tick();
      cmd_valid = 1'b0; host_wr_en = 1'b0; host_rd_en = 1'b0;
      cnt = 0;
      while (done !== 1'b1 && cnt < 400) begin
        tick();
        cnt++;
      end
      for (int e = 0; e < 64; e++) mdl[2][e] = mdl[0][e] + mdl[1][e];
      for (int c = 0; c < 10; c++) begin
        tick();
        check(done === 1'b0, "R9 no second command", 64'(done), 64'h0);
      end
      check(q_exp.size() == 0, "R9 no read while busy", 64'(q_exp.size()), 64'h0);
      read_reg(7, "R9");
      read_reg(2, "R9");
    end

    repeat (5) tick();
    check(q_exp.size() == 0, "R2 all reads returned", 64'(q_exp.size()), 64'h0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule